// File: doc/BRIEF.md
# Byte-Parallel CRC-16 Packet Engine

This block produces the 16-bit CCITT cyclic redundancy check (generator x^16 + x^12 + x^5 + 1, written 0x1021, starting remainder zero) of a packet delivered one byte per clock. It does not shift bits one at a time. Each byte is reduced in a single cycle by a fixed set of XOR equations. The resulting 16-bit residue is then carried forward: its upper byte is folded into the next data byte, and its lower byte into the byte after that.

Once the final data byte has been taken, two zero bytes close the packet. These take one cycle each and absorb the residue still outstanding. The check value is then presented together with a one-cycle done pulse. A 128-byte packet therefore completes two cycles after its last byte. The bit-serial form of the same computation needs 1040 cycles.

A packet opens with a start marker and closes with an end marker, both qualified by the valid strobe. Valid may drop between bytes without harm. The engine walks through four named states:
- **ST_IDLE**: waiting for a start-marked byte.
- **ST_BODY**: taking data bytes.
- **ST_FLUSH_HI**: the first zero byte, which absorbs the upper residue byte.
- **ST_FLUSH_LO**: the second zero byte, which absorbs the lower residue byte and raises done.

The transitions are as follows:
- ST_IDLE moves to ST_BODY on a valid start byte, or straight to ST_FLUSH_HI when that byte also carries the end marker.
- ST_BODY moves to ST_FLUSH_HI on a valid end-marked byte and otherwise stays in ST_BODY.
- ST_FLUSH_HI always moves to ST_FLUSH_LO.
- ST_FLUSH_LO always returns to ST_IDLE.

Top module: `crc16_pkt_engine`

## Requirements
- R1: After reset, `crc_out` is 0x0000 and `crc_done` is 0.
- R2: A byte is reduced with bit M0 as the least significant input bit. A packet holding only 0x41 yields 0x58E5.
- R3: For any packet of one or more bytes, `crc_out` equals the bit-serial augmented remainder. That remainder is computed by feeding each byte most significant bit first, then 16 zero bits, through a shift register with feedback polynomial 0x1021 and starting value 0. For example, the ASCII string "123456789" yields 0x31C3.
- R4: Cycles with `in_valid` low inside a packet have no effect on the result.
- R5: A valid byte with `in_sop` high clears the residue before it is reduced, including in the middle of a packet, so the earlier bytes are discarded.
- R6: Call the edge that takes the end-marked byte E0. `crc_done` is high for exactly the one cycle that follows edge E0+2, and `crc_out` carries the new result in that same cycle.
- R7: `crc_out` keeps its value in every cycle in which `crc_done` is low.
- R8: Valid bytes are ignored, with no effect on any later result and no extra done pulse, when they arrive without `in_sop` in ST_IDLE or when they arrive during the two flush cycles.
- R9: A byte with `in_sop` and `in_eop` both high forms a complete one-byte packet. A new packet may start in the cycle in which `crc_done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Qualifies the byte and markers in this cycle |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_byte | input | 8 | Packet data byte |
| crc_out | output | 16 | Check value of the most recent packet |
| crc_done | output | 1 | One-cycle pulse marking a new `crc_out` |

## Verification
The check value is due two edges after the edge that takes the end-marked byte. Each task therefore drives inputs on the falling edge. It confirms that `crc_done` is still low after the first of those two edges, then samples `crc_done` and `crc_out` on the falling edge after the second, and confirms that the pulse is gone one edge later. Ignored stimulus is driven during the flush cycles or while idle, and its absence of effect is then shown through the next done pulse and the held `crc_out`. Every expected value comes from a bit-serial model that appends sixteen zero bits, together with two fixed known answers.

// File: rtl/crc16_pkt_pkg.sv
package crc16_pkt_pkg;
    localparam int CRC_W  = 16;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BODY,
        ST_FLUSH_HI,
        ST_FLUSH_LO
    } eng_state_t;
endpackage

// File: rtl/crc16_byte_eq.sv
// Closed-form reduction of one byte placed above sixteen zero bits.
module crc16_byte_eq
    import crc16_pkt_pkg::*;
(
    input  logic [BYTE_W-1:0] m,
    output logic [CRC_W-1:0]  d
);
    always_comb begin
        d[0]  = m[0] ^ m[4];
        d[1]  = m[1] ^ m[5];
        d[2]  = m[2] ^ m[6];
        d[3]  = m[3] ^ m[7];
        d[4]  = m[4];
        d[5]  = m[0] ^ m[4] ^ m[5];
        d[6]  = m[1] ^ m[5] ^ m[6];
        d[7]  = m[2] ^ m[6] ^ m[7];
        d[8]  = m[3] ^ m[7];
        d[9]  = m[4];
        d[10] = m[5];
        d[11] = m[6];
        d[12] = m[0] ^ m[4] ^ m[7];
        d[13] = m[1] ^ m[5];
        d[14] = m[2] ^ m[6];
        d[15] = m[3] ^ m[7];
    end
endmodule

// File: rtl/crc16_fold_acc.sv
// Residue register: upper half is owed to the next byte, lower half to the one after.
module crc16_fold_acc
    import crc16_pkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic              restart,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [CRC_W-1:0]  rem_q
);
    logic [CRC_W-1:0]  seed;
    logic [BYTE_W-1:0] folded;
    logic [CRC_W-1:0]  reduced;

    always_comb begin
        seed   = restart ? '0 : rem_q;
        folded = byte_in ^ seed[CRC_W-1 -: BYTE_W];
    end

    crc16_byte_eq u_eq (
        .m (folded),
        .d (reduced)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (take) begin
            rem_q <= {seed[BYTE_W-1:0] ^ reduced[CRC_W-1 -: BYTE_W],
                      reduced[BYTE_W-1:0]};
        end
    end

    // R4 / R8: with no byte taken the residue must not move
    assert_rem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(rem_q));
endmodule

// File: rtl/crc16_pkt_fsm.sv
module crc16_pkt_fsm
    import crc16_pkt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sop,
    input  logic in_eop,
    output logic take,
    output logic restart,
    output logic flush_hi,
    output logic flush_lo
);
    eng_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (in_valid && in_sop)
                    state_d = in_eop ? ST_FLUSH_HI : ST_BODY;
            end
            ST_BODY: begin
                if (in_valid && in_eop)
                    state_d = ST_FLUSH_HI;
            end
            ST_FLUSH_HI: state_d = ST_FLUSH_LO;
            ST_FLUSH_LO: state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        take     = 1'b0;
        restart  = 1'b0;
        flush_hi = 1'b0;
        flush_lo = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                take    = in_valid && in_sop;
                restart = in_valid && in_sop;
            end
            ST_BODY: begin
                take    = in_valid;
                restart = in_valid && in_sop;
            end
            ST_FLUSH_HI: flush_hi = 1'b1;
            ST_FLUSH_LO: flush_lo = 1'b1;
            default: ;
        endcase
    end

    // R6: the two zero-byte cycles always run back to back
    assert_flush_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_hi |=> flush_lo);
    // R8: nothing is taken while flushing
    assert_flush_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_hi || flush_lo) |-> !take);
    // R6: an end-marked byte taken leads straight into the flush
    assert_eop_to_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_eop) |=> flush_hi);
endmodule

// File: rtl/crc16_pkt_engine.sv
module crc16_pkt_engine
    import crc16_pkt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [BYTE_W-1:0] in_byte,
    output logic [CRC_W-1:0]  crc_out,
    output logic              crc_done
);
    logic              take, restart, flush_hi, flush_lo;
    logic [CRC_W-1:0]  rem_q;
    logic [BYTE_W-1:0] res_hi_q;
    localparam logic [BYTE_W-1:0] ZERO_BYTE = '0;

    crc16_pkt_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sop   (in_sop),
        .in_eop   (in_eop),
        .take     (take),
        .restart  (restart),
        .flush_hi (flush_hi),
        .flush_lo (flush_lo)
    );

    crc16_fold_acc u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .restart (restart),
        .byte_in (in_byte),
        .rem_q   (rem_q)
    );

    // The appended zero bytes absorb the outstanding residue, one per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_hi_q <= '0;
            crc_out  <= '0;
            crc_done <= 1'b0;
        end else begin
            crc_done <= 1'b0;
            if (flush_hi)
                res_hi_q <= ZERO_BYTE ^ rem_q[CRC_W-1 -: BYTE_W];
            if (flush_lo) begin
                crc_out  <= {res_hi_q, ZERO_BYTE ^ rem_q[BYTE_W-1:0]};
                crc_done <= 1'b1;
            end
        end
    end

    // R6: done lasts a single cycle
    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crc_done |=> !crc_done);
    // R6: done only follows the second flush cycle
    assert_done_after_flush_R6: assert property (@(posedge clk) disable iff (!rst_n)
        crc_done |-> $past(flush_lo));
    // R7: the result is held between pulses
    assert_crc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !crc_done |-> $stable(crc_out));
endmodule

// File: tb/tb_crc16_pkt_engine.sv
`timescale 1ns/1ps
module tb_crc16_pkt_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic [15:0] crc_out;
    logic        crc_done;

    int total = 0;
    int bad   = 0;
    bit finished = 0;
    logic [7:0] pkt [256];

    always #5 clk = ~clk;

    crc16_pkt_engine dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
        .in_eop(in_eop), .in_byte(in_byte), .crc_out(crc_out), .crc_done(crc_done)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Bit-serial augmented model: message MSB first, then sixteen zero bits.
    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] r = 16'h0000;
        logic        top;
        for (int i = 0; i < n + 2; i++) begin
            for (int b = 7; b >= 0; b--) begin
                top = r[15];
                r   = {r[14:0], (i < n) ? pkt[i][b] : 1'b0};
                if (top) r = r ^ 16'h1021;
            end
        end
        return r;
    endfunction

    task automatic cyc(input logic v, input logic s, input logic e, input logic [7:0] d);
        in_valid = v; in_sop = s; in_eop = e; in_byte = d;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic send_pkt(input int n, input int gap_every);
        for (int i = 0; i < n; i++) begin
            if (gap_every != 0 && i != 0 && (i % gap_every) == 0)
                cyc(1'b0, 1'b0, 1'b0, 8'hA5);
            cyc(1'b1, i == 0, i == n - 1, pkt[i]);
        end
    endtask

    // Called at the falling edge after E0 (the edge that took the end byte).
    task automatic finish_check(input string tag, input logic [15:0] exp);
        in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
        @(posedge clk); @(negedge clk);
        check({tag, " R6 no early done"}, {15'd0, crc_done}, 16'd0);
        @(posedge clk); @(negedge clk);
        check({tag, " R6 done due"}, {15'd0, crc_done}, 16'd1);
        check({tag, " crc"}, crc_out, exp);
    endtask

    task automatic t_reset();
        check("R1 crc_out reset", crc_out, 16'h0000);
        check("R1 done reset", {15'd0, crc_done}, 16'd0);
    endtask

    task automatic t_single();
        pkt[0] = 8'h41;
        send_pkt(1, 0);
        finish_check("R2 R9 single 0x41", 16'h58E5);
        check("R2 model agrees", ref_crc(1), 16'h58E5);
        @(posedge clk); @(negedge clk);
        check("R6 pulse width", {15'd0, crc_done}, 16'd0);
    endtask

    task automatic t_string();
        string s = "123456789";
        for (int i = 0; i < 9; i++) pkt[i] = s[i];
        send_pkt(9, 0);
        finish_check("R3 known string", 16'h31C3);
    endtask

    task automatic t_patterns();
        for (int i = 0; i < 2; i++) pkt[i] = 8'hFF;
        send_pkt(2, 0);
        finish_check("R3 two bytes", ref_crc(2));
        for (int i = 0; i < 128; i++) pkt[i] = 8'((i * 7 + 3) ^ (i >> 2));
        send_pkt(128, 0);
        finish_check("R3 128 bytes", ref_crc(128));
        // R9: next packet starts during the done cycle
        for (int i = 0; i < 5; i++) pkt[i] = 8'(8'h10 + i * 33);
        send_pkt(5, 0);
        finish_check("R9 back to back", ref_crc(5));
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 20; i++) pkt[i] = 8'(i * 29 + 1);
        send_pkt(20, 3);
        finish_check("R4 gaps", ref_crc(20));
    endtask

    task automatic t_restart();
        cyc(1'b1, 1'b1, 1'b0, 8'hDE);
        cyc(1'b1, 1'b0, 1'b0, 8'hAD);
        cyc(1'b1, 1'b0, 1'b0, 8'hBE);
        for (int i = 0; i < 6; i++) pkt[i] = 8'(8'hC0 ^ (i * 5));
        send_pkt(6, 0);
        finish_check("R5 restart", ref_crc(6));
    endtask

    task automatic t_ignore();
        logic [15:0] held;
        for (int i = 0; i < 4; i++) pkt[i] = 8'(i + 8'h61);
        send_pkt(4, 0);
        // R8: stray bytes during both flush cycles
        in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_byte = 8'h77;
        @(posedge clk); @(negedge clk);
        in_byte = 8'h99;
        @(posedge clk); @(negedge clk);
        check("R8 flush stray crc", crc_out, ref_crc(4));
        check("R8 done once", {15'd0, crc_done}, 16'd1);
        held = crc_out;
        // R8: valid bytes without a start marker while idle
        for (int k = 0; k < 4; k++) cyc(1'b1, 1'b0, 1'b1, 8'(k * 51));
        check("R8 no extra done", {15'd0, crc_done}, 16'd0);
        check("R7 crc held", crc_out, held);
        send_pkt(4, 0);
        finish_check("R8 next packet clean", ref_crc(4));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk); @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_string();
        t_patterns();
        t_gaps();
        t_restart();
        t_ignore();
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule